// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Counter

This block is a small synchronous up-counter, four bits wide by default. Every state flop is clocked on the same rising edge, so all count bits change together. A build parameter chooses between plain binary counting, which wraps after the all-ones value, and decade counting, which wraps after nine. A second build parameter decides whether the active-low clear acts at once (asynchronous) or at the next rising edge (synchronous).

A parallel load with an active-low strobe presets the count to a data word at the next edge. Two active-high enables, P and T, must both be high for the count to advance. T also gates the carry output. The carry output is high while T is high and the count sits at its terminal value. It is built to drive the T input of the next stage, so several stages chain into a wider synchronous counter with no extra logic. In the synchronous-clear build, an external decode of a chosen count can drive the clear and shorten the count length.

Top module: `presettable_counter`

## Requirements
- R1: With SYNC_CLR=0, rst_ni low forces count_o to 0 at once, without waiting for a clock edge. This overrides load and both enables.
- R2: With SYNC_CLR=1, rst_ni low leaves count_o unchanged until the next rising edge, and that edge sets it to 0. This holds whatever the levels of load_ni, en_p_i and en_t_i, so clear wins over load.
- R3: When load_ni is low at a rising edge and clear is not active, count_o takes data_i at that edge, whatever the levels of en_p_i and en_t_i.
- R4: With rst_ni and load_ni high, count_o advances by one at a rising edge only if en_p_i and en_t_i are both high. Otherwise it holds its value.
- R5: With DECADE=0, an enabled count from 15 goes to 0.
- R6: With DECADE=1, an enabled count from 9 goes to 0.
- R7: With DECADE=1, a loaded value from 10 to 15 keeps counting up by one per enabled edge, goes from 15 to 0, and then stays in the range 0 to 9.
- R8: carry_o is 1 exactly when en_t_i is 1 and count_o equals the terminal value: 15 with DECADE=0 and 9 with DECADE=0's counterpart DECADE=1. It follows en_t_i without waiting for a clock edge.
- R9: Three binary stages, with P tied high and each stage's carry_o driving the next stage's en_t_i, count as one 12-bit synchronous counter. It goes from 4095 to 0, and the last stage's carry is high only at 4095 while the first stage's T is high.
- R10: In a synchronous-clear chain, feeding the low-active decode of a count value L to rst_ni makes the counter run 0, 1, ..., L, 0, so it never exceeds L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock for all state |
| rst_ni | input | 1 | Active-low clear; immediate or edge-timed per SYNC_CLR |
| load_ni | input | 1 | Active-low parallel preset strobe |
| data_i | input | WIDTH | Preset value |
| en_p_i | input | 1 | Count enable that does not affect the carry |
| en_t_i | input | 1 | Count enable that also gates carry_o |
| count_o | output | WIDTH | Current count |
| carry_o | output | 1 | Terminal-count carry for cascading |

## Verification
The bench builds three configurations:
- A binary counter with immediate clear. It brings clear in the middle of a cycle, and the 15-to-0 wrap, within reach.
- A decade counter with edge-timed clear, sharing the same enables. It exposes the 9-to-0 wrap, out-of-range loads, and clear winning over a load in the same cycle.
- A chain of three binary stages with edge-timed clear. It runs the full 12-bit sequence and its wrap, irregular enable patterns, and a count length shortened by decoding 199 onto the clear.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
package cnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } cnt_op_e;

  function automatic int term_value(input bit decade, input int width);
    return decade ? 9 : (1 << width) - 1;
  endfunction

endpackage

// File: rtl/cnt_ctrl.sv
`timescale 1ns/1ps
// Per-edge operation select: load beats count, count beats hold.
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    load_ni,
  input  logic    en_p_i,
  input  logic    en_t_i,
  output cnt_op_e op_o
);

  always_comb begin
    if (!load_ni)                op_o = OP_LOAD;
    else if (en_p_i && en_t_i)   op_o = OP_COUNT;
    else                         op_o = OP_HOLD;
  end

endmodule

// File: rtl/cnt_next.sv
`timescale 1ns/1ps
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] data_i,
  input  cnt_op_e          op_i,
  output logic [WIDTH-1:0] d_o
);

  localparam int              TERM   = term_value(DECADE, WIDTH);
  localparam logic [WIDTH-1:0] TERM_W = TERM[WIDTH-1:0];

  logic [WIDTH-1:0] inc;

  generate
    if (DECADE) begin : g_dec
      // Out-of-range values fall through the natural wrap back into 0..9.
      assign inc = (q_i == TERM_W) ? '0 : q_i + 1'b1;
    end else begin : g_bin
      assign inc = q_i + 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (op_i)
      OP_LOAD:  d_o = data_i;
      OP_COUNT: d_o = inc;
      default:  d_o = q_i;
    endcase
  end

endmodule

// File: rtl/cnt_state.sv
`timescale 1ns/1ps
module cnt_state #(
  parameter int WIDTH    = 4,
  parameter bit SYNC_CLR = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (SYNC_CLR) begin : g_sync
      always_ff @(posedge clk_i) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= d_i;
      end
    end else begin : g_async
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= d_i;
      end
    end
  endgenerate

endmodule

// File: rtl/cnt_carry.sv
`timescale 1ns/1ps
module cnt_carry
  import cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             en_t_i,
  output logic             carry_o
);

  localparam int              TERM   = term_value(DECADE, WIDTH);
  localparam logic [WIDTH-1:0] TERM_W = TERM[WIDTH-1:0];

  // T is fed forward so a stalled upstream stage blocks the whole chain.
  assign carry_o = en_t_i && (q_i == TERM_W);

endmodule

// File: rtl/presettable_counter.sv
`timescale 1ns/1ps
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter bit DECADE   = 1'b0,
  parameter bit SYNC_CLR = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             en_p_i,
  input  logic             en_t_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o
);

  cnt_op_e          op;
  logic [WIDTH-1:0] d;
  logic [WIDTH-1:0] q;

  cnt_ctrl u_ctrl (
    .load_ni (load_ni),
    .en_p_i  (en_p_i),
    .en_t_i  (en_t_i),
    .op_o    (op)
  );

  cnt_next #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
    .q_i    (q),
    .data_i (data_i),
    .op_i   (op),
    .d_o    (d)
  );

  cnt_state #(.WIDTH(WIDTH), .SYNC_CLR(SYNC_CLR)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (d),
    .q_o    (q)
  );

  cnt_carry #(.WIDTH(WIDTH), .DECADE(DECADE)) u_carry (
    .q_i     (q),
    .en_t_i  (en_t_i),
    .carry_o (carry_o)
  );

  assign count_o = q;

endmodule

// File: rtl/presettable_counter_chk.sv
`timescale 1ns/1ps
module presettable_counter_chk
  import cnt_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter bit DECADE   = 1'b0,
  parameter bit SYNC_CLR = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic             en_p_i,
  input logic             en_t_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_o
);

  localparam int TERM = term_value(DECADE, WIDTH);

  generate
    if (SYNC_CLR) begin : g_sync
      a_r2_sync_clear: assert property (@(posedge clk_i)
        !rst_ni |=> count_o == '0);
    end else begin : g_async
      a_r1_async_clear: assert property (@(posedge clk_i)
        !rst_ni |-> count_o == '0);
    end
  endgenerate

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(en_p_i && en_t_i)) |=> $stable(count_o));

  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && en_p_i && en_t_i && int'(count_o) != TERM)
      |=> count_o == $past(count_o) + 1'b1);

  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && en_p_i && en_t_i && int'(count_o) == TERM) |=> count_o == '0);

  a_r8_carry_t: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (en_t_i && int'(count_o) == TERM));

  a_r8_carry_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_t_i && int'(count_o) == TERM) |-> carry_o);

endmodule

bind presettable_counter presettable_counter_chk #(
  .WIDTH(WIDTH), .DECADE(DECADE), .SYNC_CLR(SYNC_CLR)
) u_chk (.*);

// File: tb/presettable_counter_tb.sv
`timescale 1ns/1ps
module presettable_counter_tb;

  localparam int          SHORT_LIM = 199;
  localparam logic [11:0] SHORT_W   = 12'd199;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  // single-stage stimulus
  logic rst_n, load_n, p, t;
  logic [3:0] data_b, data_d;
  logic [3:0] bin_q, dec_q;
  logic bin_c, dec_c;

  // chain stimulus
  logic ch_rst_n, ch_load_n, ch_en, short_en;
  logic [11:0] ch_data, ch_q;
  logic [2:0] ch_c;
  logic [3:0] ch_t;
  logic ch_clr_n;

  string bin_tag = "R1", dec_tag = "R2", ch_tag = "R9";

  presettable_counter #(.WIDTH(4), .DECADE(1'b0), .SYNC_CLR(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data_b),
    .en_p_i(p), .en_t_i(t), .count_o(bin_q), .carry_o(bin_c));

  presettable_counter #(.WIDTH(4), .DECADE(1'b1), .SYNC_CLR(1'b1)) u_dec (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data_d),
    .en_p_i(p), .en_t_i(t), .count_o(dec_q), .carry_o(dec_c));

  assign ch_clr_n = ch_rst_n & ~(short_en & (ch_q == SHORT_W));
  assign ch_t[0]  = ch_en;

  for (genvar g = 0; g < 3; g++) begin : g_chain
    presettable_counter #(.WIDTH(4), .DECADE(1'b0), .SYNC_CLR(1'b1)) u_stage (
      .clk_i(clk), .rst_ni(ch_clr_n), .load_ni(ch_load_n),
      .data_i(ch_data[4*g +: 4]), .en_p_i(1'b1), .en_t_i(ch_t[g]),
      .count_o(ch_q[4*g +: 4]), .carry_o(ch_c[g]));
    assign ch_t[g+1] = ch_c[g];
  end

  // reference models
  int m_bin, m_dec, m_ch;

  always @(posedge clk or negedge rst_n)
    if (!rst_n)          m_bin <= 0;
    else if (!load_n)    m_bin <= int'(data_b);
    else if (p && t)     m_bin <= (m_bin + 1) % 16;

  always @(posedge clk)
    if (!rst_n)          m_dec <= 0;
    else if (!load_n)    m_dec <= int'(data_d);
    else if (p && t)     m_dec <= (m_dec == 9) ? 0 : (m_dec + 1) % 16;

  always @(posedge clk)
    if (!ch_rst_n || (short_en && m_ch == SHORT_LIM)) m_ch <= 0;
    else if (!ch_load_n) m_ch <= int'(ch_data);
    else if (ch_en)      m_ch <= (m_ch + 1) % 4096;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ch_carry_exp();
    int c0, c1, c2;
    c0 = (ch_en && (m_ch % 16) == 15) ? 1 : 0;
    c1 = (c0 == 1 && ((m_ch / 16) % 16) == 15) ? 1 : 0;
    c2 = (c1 == 1 && (m_ch / 256) == 15) ? 1 : 0;
    return c0 + 2 * c1 + 4 * c2;
  endfunction

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk(bin_tag, int'(bin_q), m_bin);
      chk(dec_tag, int'(dec_q), m_dec);
      chk("R8", int'(bin_c), (t && m_bin == 15) ? 1 : 0);
      chk("R8", int'(dec_c), (t && m_dec == 9) ? 1 : 0);
      chk(ch_tag, int'(ch_q), m_ch);
      chk("R9", int'(ch_c), ch_carry_exp());
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  int max_seen;

  initial begin
    rst_n = 0; load_n = 1; p = 0; t = 0; data_b = 0; data_d = 0;
    ch_rst_n = 0; ch_load_n = 1; ch_en = 0; short_en = 0; ch_data = 0;
    cyc(3);
    started = 1'b1;
    chk("R1", int'(bin_q), 0);
    chk("R2", int'(dec_q), 0);
    rst_n = 1; ch_rst_n = 1;

    // free count: binary and decade wraps
    bin_tag = "R5"; dec_tag = "R6";
    p = 1; t = 1;
    cyc(40);

    // enables: each alone holds
    bin_tag = "R4"; dec_tag = "R4";
    p = 0; cyc(6);
    p = 1; t = 0; cyc(6);

    // carry follows T at terminal count
    bin_tag = "R3"; dec_tag = "R3";
    load_n = 0; data_b = 15; data_d = 9; p = 0; t = 0;
    cyc(1);
    load_n = 1; t = 1;
    #0.5;
    chk("R8", int'(bin_c), 1);
    chk("R8", int'(dec_c), 1);
    t = 0;
    #0.5;
    chk("R8", int'(bin_c), 0);
    chk("R8", int'(dec_c), 0);
    p = 1; t = 1;
    cyc(1);
    chk("R5", int'(bin_q), 0);
    chk("R6", int'(dec_q), 0);

    // load while counting, then out-of-range decade value
    bin_tag = "R3"; dec_tag = "R7";
    load_n = 0; data_b = 6; data_d = 12;
    cyc(1);
    chk("R3", int'(bin_q), 6);
    chk("R7", int'(dec_q), 12);
    load_n = 1;
    cyc(4);
    chk("R7", int'(dec_q), 0);
    cyc(12);

    // load with both enables low
    bin_tag = "R3"; dec_tag = "R3";
    p = 0; t = 0; load_n = 0; data_b = 10; data_d = 3;
    cyc(1);
    chk("R3", int'(bin_q), 10);
    chk("R3", int'(dec_q), 3);
    load_n = 1; p = 1; t = 1;
    cyc(3);

    // clear mid-cycle together with a load
    bin_tag = "R1"; dec_tag = "R2";
    begin
      int dec_before;
      dec_before = m_dec;
      rst_n = 0; load_n = 0; data_b = 7; data_d = 7;
      #0.5;
      chk("R1", int'(bin_q), 0);
      chk("R2", int'(dec_q), dec_before);
    end
    cyc(1);
    chk("R2", int'(dec_q), 0);
    chk("R1", int'(bin_q), 0);
    cyc(2);
    rst_n = 1; load_n = 1; p = 0; t = 0;
    cyc(2);

    // 12-bit chain
    ch_tag = "R9";
    ch_en = 1;
    cyc(4095);
    chk("R9", int'(ch_q), 4095);
    chk("R9", int'(ch_c), 7);
    cyc(1);
    chk("R9", int'(ch_q), 0);
    ch_load_n = 0; ch_data = 12'hFFA;
    cyc(1);
    ch_load_n = 1;
    cyc(10);
    for (int i = 0; i < 200; i++) begin
      ch_en = (i % 3) != 0;
      cyc(1);
    end

    // shortened count length via synchronous clear decode
    ch_tag = "R10";
    ch_en = 1;
    ch_rst_n = 0;
    cyc(1);
    ch_rst_n = 1; short_en = 1;
    max_seen = 0;
    for (int i = 0; i < 700; i++) begin
      cyc(1);
      if (int'(ch_q) > max_seen) max_seen = int'(ch_q);
    end
    chk("R10", max_seen, SHORT_LIM);
    short_en = 0;
    cyc(2);
    finish_run();
  end

endmodule